// File: doc/BRIEF.md
# Pipelined Quadratic Discriminant Classifier

The block takes the three signed integer coefficients of a quadratic `a*x^2 + b*x + c` together with a valid strobe. It returns the discriminant `b*b - 4*a*c` and a two-bit count of the real roots, with a matching output valid strobe. The `4*a*c` term is formed by shifting the `a*c` product left by two bit positions, so no multiplier is spent on the constant. The block computes neither the roots, nor floating-point values, nor backpressure. It is meant to sit in a streaming datapath that classifies one coefficient set per slot.

A compile-time parameter picks one of two schedules. The dual schedule gives `b*b` and `a*c` a seven-stage multiplier each. It then spends one stage on the shift, one on the subtraction and one on the comparison and output write. It accepts a new coefficient set on every cycle. The shared schedule sends `b*b` and then `a*c` through a single four-stage multiplier on consecutive cycles. It holds the first product until the second one leaves the multiplier, then shifts and subtracts in one stage and compares in the next. It accepts a set every second cycle and signals this on a ready output.

Top module: `qdisc_pipe`

## Requirements
- R1: `out_disc` equals `b*b - 4*a*c`, computed exactly for every pair of signed WIDTH-bit inputs. It is carried as a two's-complement value of 2*WIDTH+3 bits, with the `4*a*c` term produced by a left shift of two on the `a*c` product.
- R2: `out_roots` is 2 (binary 10) when the discriminant is above zero, 1 (binary 01) when it is zero and 0 (binary 00) when it is negative. The code 3 never appears while `out_valid` is high.
- R3: With SHARED=0, `in_ready` is always high and a set is accepted on every cycle that `in_valid` is high. Its result is presented with `out_valid` exactly 10 cycles after the accepting clock edge, so back-to-back sets give back-to-back results.
- R4: With SHARED=1, `in_ready` is low in the cycle that follows an accepting edge and high otherwise. The result is presented exactly 7 cycles after the accepting edge.
- R5: Each accepted set produces exactly one `out_valid` pulse, and results leave in acceptance order. Input presented while `in_ready` is low is ignored and produces no result.
- R6: A synchronous active-high `rst` clears every in-flight valid bit and the shared-mode phase. After reset `out_valid` is low and `in_ready` is high until new sets are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Coefficient set present |
| in_ready | output | 1 | A set may be accepted this cycle |
| in_a | input | WIDTH | Signed quadratic coefficient |
| in_b | input | WIDTH | Signed linear coefficient |
| in_c | input | WIDTH | Signed constant coefficient |
| out_valid | output | 1 | Result present this cycle |
| out_disc | output | 2*WIDTH+3 | Signed discriminant |
| out_roots | output | 2 | Real-root count: 2, 1 or 0 |

## Verification
On every cycle the assertions check several things. The discriminant must equal the value computed from the inputs accepted a fixed latency earlier, and it must keep its top two bits equal. The root code must agree with the sign of the discriminant that goes out beside it. `out_valid` must follow acceptance by exactly the mode's latency, and shared mode must drop ready after each acceptance. Other behaviours show only in the bench's scenarios. These are the exhaustive sweep of all small-width coefficient triples through both schedules, the order of results across idle gaps, the rejection of stimulus offered while ready is low, and the loss of in-flight results when reset arrives mid-stream.

// File: rtl/qdisc_pkg.sv
package qdisc_pkg;

    typedef enum logic [1:0] {
        ROOTS_NONE = 2'd0,
        ROOTS_ONE  = 2'd1,
        ROOTS_TWO  = 2'd2
    } roots_e;

    localparam int unsigned DUAL_MUL_STAGES   = 7;
    localparam int unsigned SHARED_MUL_STAGES = 4;

    // dual: product chain, shift, subtract, compare
    // shared: second operand pair enters one cycle late, chain, shift+subtract, compare
    function automatic int unsigned total_latency(input bit shared);
        return shared ? (1 + SHARED_MUL_STAGES + 2) : (DUAL_MUL_STAGES + 3);
    endfunction

    function automatic roots_e classify(input logic negative, input logic is_zero);
        if (negative)     return ROOTS_NONE;
        else if (is_zero) return ROOTS_ONE;
        else              return ROOTS_TWO;
    endfunction

endpackage

// File: rtl/qdisc_mult_pipe.sv
module qdisc_mult_pipe #(
    parameter int W      = 16,
    parameter int STAGES = 7
) (
    input  logic                  clk,
    input  logic signed [W-1:0]   op_x,
    input  logic signed [W-1:0]   op_y,
    output logic signed [2*W-1:0] prod
);
    localparam int PW = 2 * W;

    logic signed [PW-1:0] chain_d [STAGES];
    logic signed [PW-1:0] chain_q [STAGES];

    always_comb begin
        chain_d[0] = op_x * op_y;
        for (int k = 1; k < STAGES; k++) begin
            chain_d[k] = chain_q[k-1];
        end
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < STAGES; k++) begin
            chain_q[k] <= chain_d[k];
        end
    end

    assign prod = chain_q[STAGES-1];
endmodule

// File: rtl/qdisc_valid_line.sv
module qdisc_valid_line #(
    parameter int DEPTH = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [DEPTH-1:0] line_d;
    logic [DEPTH-1:0] line_q;

    always_comb begin
        line_d = {line_q[DEPTH-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (rst) line_q <= '0;
        else     line_q <= line_d;
    end

    assign dout = line_q[DEPTH-1];
endmodule

// File: rtl/qdisc_pipe.sv
module qdisc_pipe
    import qdisc_pkg::*;
#(
    parameter int WIDTH  = 16,
    parameter bit SHARED = 1'b0
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic signed [WIDTH-1:0]     in_a,
    input  logic signed [WIDTH-1:0]     in_b,
    input  logic signed [WIDTH-1:0]     in_c,
    output logic                        out_valid,
    output logic signed [2*WIDTH+2:0]   out_disc,
    output logic [1:0]                  out_roots
);
    localparam int PW         = 2 * WIDTH;
    localparam int DW         = PW + 3;
    localparam int MUL_STAGES = SHARED ? int'(SHARED_MUL_STAGES) : int'(DUAL_MUL_STAGES);
    localparam int LAT        = int'(total_latency(SHARED));

    typedef struct packed {
        logic                    phase;   // shared: second operand pair in flight
        logic signed [WIDTH-1:0] a_hold;
        logic signed [WIDTH-1:0] c_hold;
        logic signed [DW-1:0]    bb_ext;  // dual: stage 8, shared: held first product
        logic signed [DW-1:0]    ac4;     // dual: stage 8 shifted product
        logic signed [DW-1:0]    diff;    // dual: stage 9, shared: shift+subtract stage
        logic signed [DW-1:0]    disc;
        logic [1:0]              roots;
    } pipe_st_t;

    pipe_st_t st_d, st_q;

    logic                    accept;
    logic signed [WIDTH-1:0] m0_x, m0_y;
    logic signed [PW-1:0]    m0_p, m1_p;
    logic signed [DW-1:0]    p0_ext, p1_ext;

    generate
        if (SHARED) begin : g_shared
            qdisc_mult_pipe #(.W(WIDTH), .STAGES(MUL_STAGES)) u_mul0 (
                .clk (clk), .op_x(m0_x), .op_y(m0_y), .prod(m0_p)
            );
            assign m1_p = '0;
        end else begin : g_dual
            qdisc_mult_pipe #(.W(WIDTH), .STAGES(MUL_STAGES)) u_mul0 (
                .clk (clk), .op_x(m0_x), .op_y(m0_y), .prod(m0_p)
            );
            qdisc_mult_pipe #(.W(WIDTH), .STAGES(MUL_STAGES)) u_mul1 (
                .clk (clk), .op_x(in_a), .op_y(in_c), .prod(m1_p)
            );
        end
    endgenerate

    assign in_ready = SHARED ? ~st_q.phase : 1'b1;

    always_comb begin
        st_d   = st_q;
        accept = in_valid && in_ready;
        p0_ext = {{3{m0_p[PW-1]}}, m0_p};
        p1_ext = {{3{m1_p[PW-1]}}, m1_p};

        if (SHARED) begin
            // b*b on the accepting cycle, a*c from the holding registers next cycle
            m0_x       = st_q.phase ? st_q.a_hold : in_b;
            m0_y       = st_q.phase ? st_q.c_hold : in_b;
            st_d.phase = st_q.phase ? 1'b0 : accept;
            if (accept) begin
                st_d.a_hold = in_a;
                st_d.c_hold = in_c;
            end
            st_d.bb_ext = p0_ext;
            st_d.ac4    = '0;
            st_d.diff   = st_q.bb_ext - (p0_ext <<< 2);
        end else begin
            m0_x        = in_b;
            m0_y        = in_b;
            st_d.phase  = 1'b0;
            st_d.bb_ext = p0_ext;
            st_d.ac4    = p1_ext <<< 2;
            st_d.diff   = st_q.bb_ext - st_q.ac4;
        end

        st_d.disc  = st_q.diff;
        st_d.roots = classify(st_q.diff[DW-1], st_q.diff == '0);
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
        if (rst) st_q.phase <= 1'b0;
    end

    qdisc_valid_line #(.DEPTH(LAT)) u_vline (
        .clk (clk),
        .rst (rst),
        .din (accept),
        .dout(out_valid)
    );

    assign out_disc  = st_q.disc;
    assign out_roots = st_q.roots;
endmodule

// File: rtl/qdisc_checker.sv
module qdisc_checker
    import qdisc_pkg::*;
#(
    parameter int WIDTH  = 16,
    parameter bit SHARED = 1'b0
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      in_valid,
    input logic                      in_ready,
    input logic signed [WIDTH-1:0]   in_a,
    input logic signed [WIDTH-1:0]   in_b,
    input logic signed [WIDTH-1:0]   in_c,
    input logic                      out_valid,
    input logic signed [2*WIDTH+2:0] out_disc,
    input logic [1:0]                out_roots
);
    localparam int DW  = 2 * WIDTH + 3;
    localparam int LAT = int'(total_latency(SHARED));
    localparam logic signed [DW-1:0] FOUR = DW'(4);

    logic                 acc_now;
    logic signed [DW-1:0] ax, bx, cx, ref_now;
    logic [4:0]           since_q;

    always_comb begin
        acc_now = in_valid && in_ready;
        ax      = {{(DW-WIDTH){in_a[WIDTH-1]}}, in_a};
        bx      = {{(DW-WIDTH){in_b[WIDTH-1]}}, in_b};
        cx      = {{(DW-WIDTH){in_c[WIDTH-1]}}, in_c};
        ref_now = bx * bx - FOUR * ax * cx;
    end

    always_ff @(posedge clk) begin
        if (rst)                     since_q <= '0;
        else if (since_q <= 5'(LAT)) since_q <= since_q + 5'd1;
    end

    p_disc_value_r1: assert property (@(posedge clk) disable iff (rst)
        (out_valid && since_q > 5'(LAT)) |-> out_disc == $past(ref_now, LAT));

    p_no_overflow_r1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_disc[DW-1] == out_disc[DW-2]);

    p_roots_sign_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_roots == (($signed(out_disc) > 0) ? 2'd2 :
                                    (out_disc == '0)        ? 2'd1 : 2'd0));

    p_ready_dual_r3: assert property (@(posedge clk) disable iff (rst)
        !SHARED |-> in_ready);

    p_ii_shared_r4: assert property (@(posedge clk) disable iff (rst)
        (SHARED && acc_now) |=> !in_ready);

    p_valid_latency_r5: assert property (@(posedge clk) disable iff (rst)
        (since_q > 5'(LAT)) |-> out_valid == $past(acc_now, LAT));

    p_reset_clear_r6: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && in_ready));
endmodule

bind qdisc_pipe qdisc_checker #(.WIDTH(WIDTH), .SHARED(SHARED)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_a     (in_a),
    .in_b     (in_b),
    .in_c     (in_c),
    .out_valid(out_valid),
    .out_disc (out_disc),
    .out_roots(out_roots)
);

// File: tb/qdisc_pipe_bench.sv
`timescale 1ns/1ps
module qdisc_pipe_bench;
    localparam int W  = 4;
    localparam int DW = 2 * W + 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    // dual-multiplier instance
    logic                 d_in_valid = 1'b0, d_in_ready, d_out_valid;
    logic signed [W-1:0]  d_a = '0, d_b = '0, d_c = '0;
    logic signed [DW-1:0] d_disc;
    logic [1:0]           d_roots;
    // shared-multiplier instance
    logic                 s_in_valid = 1'b0, s_in_ready, s_out_valid;
    logic signed [W-1:0]  s_a = '0, s_b = '0, s_c = '0;
    logic signed [DW-1:0] s_disc;
    logic [1:0]           s_roots;

    qdisc_pipe #(.WIDTH(W), .SHARED(1'b0)) u_qdisc_pipe (
        .clk(clk), .rst(rst), .in_valid(d_in_valid), .in_ready(d_in_ready),
        .in_a(d_a), .in_b(d_b), .in_c(d_c),
        .out_valid(d_out_valid), .out_disc(d_disc), .out_roots(d_roots));

    qdisc_pipe #(.WIDTH(W), .SHARED(1'b1)) u_qdisc_pipe_sh (
        .clk(clk), .rst(rst), .in_valid(s_in_valid), .in_ready(s_in_ready),
        .in_a(s_a), .in_b(s_b), .in_c(s_c),
        .out_valid(s_out_valid), .out_disc(s_disc), .out_roots(s_roots));

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;
    int d_q_disc[$], d_q_stamp[$], s_q_disc[$], s_q_stamp[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input string what, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, got, exp, cyc);
        end
    endtask

    function automatic int ref_disc(input int a, input int b, input int c);
        return b * b - 4 * a * c;
    endfunction

    function automatic int ref_roots(input int dv);
        return (dv > 0) ? 2 : ((dv == 0) ? 1 : 0);
    endfunction

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    // output monitor and watchdog
    always @(negedge clk) begin
        if (cyc > 50000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual cycle %0d expected completion before 50000", cyc);
            finish_run();
        end
        if (!rst && d_out_valid) begin
            if (d_q_disc.size() == 0) begin
                check("R5", "dual unexpected result", 1, 0);
            end else begin
                int ed, st;
                ed = d_q_disc.pop_front();
                st = d_q_stamp.pop_front();
                check("R1", "dual discriminant", int'(d_disc), ed);
                check("R2", "dual root count", int'(d_roots), ref_roots(ed));
                check("R3", "dual latency", cyc - st, 10);
            end
        end
        if (!rst && s_out_valid) begin
            if (s_q_disc.size() == 0) begin
                check("R5", "shared unexpected result", 1, 0);
            end else begin
                int ed, st;
                ed = s_q_disc.pop_front();
                st = s_q_stamp.pop_front();
                check("R1", "shared discriminant", int'(s_disc), ed);
                check("R2", "shared root count", int'(s_roots), ref_roots(ed));
                check("R4", "shared latency", cyc - st, 7);
            end
        end
    end

    task automatic drive_dual();
        int n = 0;
        for (int a = -8; a < 8; a++)
            for (int b = -8; b < 8; b++)
                for (int c = -8; c < 8; c++) begin
                    if (n % 61 == 60) begin
                        @(negedge clk);
                        d_in_valid = 1'b0;
                        d_a = 4'sd7; d_b = 4'sd0; d_c = 4'sd7;
                    end
                    @(negedge clk);
                    check("R3", "dual ready", int'(d_in_ready), 1);
                    d_in_valid = 1'b1;
                    d_a = W'(a); d_b = W'(b); d_c = W'(c);
                    d_q_disc.push_back(ref_disc(a, b, c));
                    d_q_stamp.push_back(cyc);
                    n++;
                end
        @(negedge clk);
        d_in_valid = 1'b0;
    endtask

    task automatic drive_shared();
        int  n = 0;
        bit  just_acc = 1'b0;
        for (int a = -8; a < 8; a++)
            for (int b = -8; b < 8; b++)
                for (int c = -8; c < 8; c++) begin
                    if (just_acc) begin
                        @(negedge clk);
                        check("R4", "shared ready after accept", int'(s_in_ready), 0);
                        // offered while not ready: must be ignored (R5)
                        s_in_valid = 1'b1;
                        s_a = 4'sd7; s_b = 4'sd0; s_c = 4'sd7;
                    end
                    if (n % 53 == 52) begin
                        @(negedge clk);
                        s_in_valid = 1'b0;
                    end
                    @(negedge clk);
                    check("R4", "shared ready when idle", int'(s_in_ready), 1);
                    s_in_valid = 1'b1;
                    s_a = W'(a); s_b = W'(b); s_c = W'(c);
                    s_q_disc.push_back(ref_disc(a, b, c));
                    s_q_stamp.push_back(cyc);
                    just_acc = 1'b1;
                    n++;
                end
        @(negedge clk);
        s_in_valid = 1'b0;
    endtask

    initial begin
        // R6: reset with garbage on the inputs
        d_in_valid = 1'b1; s_in_valid = 1'b1;
        d_a = -4'sd8; d_b = 4'sd3; d_c = 4'sd5;
        s_a = -4'sd8; s_b = 4'sd3; s_c = 4'sd5;
        repeat (3) @(negedge clk);
        check("R6", "dual out_valid in reset", int'(d_out_valid), 0);
        check("R6", "shared out_valid in reset", int'(s_out_valid), 0);
        check("R6", "shared ready in reset", int'(s_in_ready), 1);
        d_in_valid = 1'b0; s_in_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check("R6", "dual ready after reset", int'(d_in_ready), 1);

        fork
            drive_dual();
            drive_shared();
        join

        for (int k = 0; k < 40; k++) begin
            if (d_q_disc.size() == 0 && s_q_disc.size() == 0) break;
            @(negedge clk);
        end
        check("R5", "dual results outstanding", d_q_disc.size(), 0);
        check("R5", "shared results outstanding", s_q_disc.size(), 0);

        // R6: reset while sets are in flight drops them
        @(negedge clk);
        d_in_valid = 1'b1; s_in_valid = 1'b1;
        d_a = 4'sd1; d_b = 4'sd5; d_c = 4'sd2;
        s_a = 4'sd1; s_b = 4'sd5; s_c = 4'sd2;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b1;
        d_in_valid = 1'b0; s_in_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        check("R6", "shared ready after mid-stream reset", int'(s_in_ready), 1);
        for (int k = 0; k < 12; k++) begin
            check("R6", "dual out_valid after reset", int'(d_out_valid), 0);
            check("R6", "shared out_valid after reset", int'(s_out_valid), 0);
            @(negedge clk);
        end
        finish_run();
    end
endmodule